// File: doc/BRIEF.md
# Multi-Condition Object Set Matcher

The block holds one fixed slice of a discretized decision table: a bank of object words, each made of equally wide attribute fields. A host fills the bank one word at a time, then presents a candidate rule as a set of attribute-value conditions. The rule has an enable bit per attribute, a value word with one field per attribute, and a mask that selects which objects take part. It pulses a start input. One clock later the block returns a bitmap with one bit per object. A bit is set when that object is selected and agrees with the rule on every enabled attribute.

Every object is compared against every enabled condition in parallel in a single combinational network. The result is captured into a register on the start edge. It is a set, not a single flag, so a controller can intersect or count it directly. Attributes that a dataset does not use are stored as zero, so datasets of different widths share one configuration.

Top module: `objset_matcher`

## Requirements
- R1: After reset, `result` and `done` are 0 and every stored object word is 0, so a query with all conditions enabled, value 0 and all objects selected returns all ones.
- R2: When `wr_en` is high at a rising clock edge, `wr_data` is stored as the word of object `wr_addr`. Later queries see that word. A write in the same cycle as `start` is not seen by that query.
- R3: With `cond_en` all zero, the result equals `obj_sel`.
- R4: A result bit whose `obj_sel` bit was 0 at start is always 0.
- R5: Attribute a occupies bits [4a+3:4a] of both an object word and `cond_val`. Result bit i is 1 exactly when `obj_sel[i]` is 1 and, for every a with `cond_en[a]` set, object i's field a equals `cond_val` field a.
- R6: `done` is 1 in exactly the cycle after the one in which `start` was sampled high, and `result` takes its new value at that same edge.
- R7: Between starts, `result` holds its value whatever `cond_en`, `cond_val`, `obj_sel` or table writes do, and `done` is 0.
- R8: A field of `cond_val` whose `cond_en` bit is clear has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 6 | Object index to write |
| wr_data | input | 64 | Object word to store |
| cond_en | input | 16 | One enable bit per attribute condition |
| cond_val | input | 64 | Required value, 4 bits per attribute |
| obj_sel | input | 64 | One select bit per object |
| start | input | 1 | Pulse that captures a match |
| result | output | 64 | Membership bitmap, one bit per object |
| done | output | 1 | One-cycle flag: result just updated |

## Verification
A wrong stored word or broken attribute comparator shows as a wrong bit in `result` on the first query that enables that attribute. That is one clock after start. The sweeps enable each attribute alone across all sixteen values, so each field of each object is reached. A broken enable gate or object mask shows as extra set bits in the same cycle. A result register that is not held, or a `done` flag with wrong timing, shows in the cycles that follow a query, while inputs and the table are changed on purpose.

// File: rtl/objset_pkg.sv
package objset_pkg;

    localparam int unsigned DEF_OBJS   = 64;
    localparam int unsigned DEF_ATTRS  = 16;
    localparam int unsigned DEF_ATTR_W = 4;

    // Field a of a packed word
    function automatic int unsigned field_lsb(input int unsigned a, input int unsigned w);
        return a * w;
    endfunction

endpackage

// File: rtl/objset_table.sv
module objset_table
    import objset_pkg::*;
#(
    parameter int unsigned N_OBJ  = DEF_OBJS,
    parameter int unsigned WORD_W = DEF_ATTRS * DEF_ATTR_W,
    localparam int unsigned ADDR_W = $clog2(N_OBJ)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    output logic [N_OBJ-1:0][WORD_W-1:0]  words
);

    logic [N_OBJ-1:0][WORD_W-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            bank_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign words = bank_q;

endmodule

// File: rtl/objset_obj_cmp.sv
module objset_obj_cmp
    import objset_pkg::*;
#(
    parameter int unsigned N_ATTR = DEF_ATTRS,
    parameter int unsigned ATTR_W = DEF_ATTR_W,
    localparam int unsigned WORD_W = N_ATTR * ATTR_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic [N_ATTR-1:0] cond_en,
    input  logic [WORD_W-1:0] cond_val,
    input  logic              sel,
    output logic              hit
);

    logic [N_ATTR-1:0] attr_ok;

    for (genvar a = 0; a < N_ATTR; a++) begin : g_attr
        localparam int unsigned LSB = a * ATTR_W;
        logic field_eq;
        assign field_eq   = (word[LSB +: ATTR_W] == cond_val[LSB +: ATTR_W]);
        assign attr_ok[a] = !cond_en[a] || field_eq;
    end

    // Empty condition set reduces to true
    assign hit = sel && (&attr_ok);

endmodule

// File: rtl/objset_matcher.sv
module objset_matcher
    import objset_pkg::*;
#(
    parameter int unsigned N_OBJ  = DEF_OBJS,
    parameter int unsigned N_ATTR = DEF_ATTRS,
    parameter int unsigned ATTR_W = DEF_ATTR_W,
    localparam int unsigned WORD_W = N_ATTR * ATTR_W,
    localparam int unsigned ADDR_W = $clog2(N_OBJ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [N_ATTR-1:0] cond_en,
    input  logic [WORD_W-1:0] cond_val,
    input  logic [N_OBJ-1:0]  obj_sel,
    input  logic              start,
    output logic [N_OBJ-1:0]  result,
    output logic              done
);

    typedef struct packed {
        logic [N_OBJ-1:0] result;
        logic             done;
    } ctrl_t;

    logic [N_OBJ-1:0][WORD_W-1:0] words;
    logic [N_OBJ-1:0]             hits;
    ctrl_t                        st_d, st_q;

    objset_table #(
        .N_OBJ  (N_OBJ),
        .WORD_W (WORD_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .words   (words)
    );

    for (genvar i = 0; i < N_OBJ; i++) begin : g_obj
        objset_obj_cmp #(
            .N_ATTR (N_ATTR),
            .ATTR_W (ATTR_W)
        ) u_cmp (
            .word     (words[i]),
            .cond_en  (cond_en),
            .cond_val (cond_val),
            .sel      (obj_sel[i]),
            .hit      (hits[i])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = start;
        if (start) begin
            st_d.result = hits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.result;
    assign done   = st_q.done;

endmodule

// File: rtl/objset_matcher_chk.sv
module objset_matcher_chk #(
    parameter int unsigned N_OBJ  = 64,
    parameter int unsigned N_ATTR = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [N_ATTR-1:0] cond_en,
    input logic [N_OBJ-1:0]  obj_sel,
    input logic [N_OBJ-1:0]  result,
    input logic              done
);

    a_r6_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    a_r6_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    a_r4_unselected_zero: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ((result & ~$past(obj_sel)) == '0));

    a_r3_empty_cond_all_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cond_en == '0) |=> (result == $past(obj_sel)));

    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));

endmodule

bind objset_matcher objset_matcher_chk #(
    .N_OBJ  (N_OBJ),
    .N_ATTR (N_ATTR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cond_en (cond_en),
    .obj_sel (obj_sel),
    .result  (result),
    .done    (done)
);

// File: tb/objset_matcher_test.sv
module objset_matcher_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [5:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [15:0] cond_en = '0;
    logic [63:0] cond_val = '0;
    logic [63:0] obj_sel = '0;
    logic        start = 0;
    logic [63:0] result;
    logic        done;

    logic [63:0] model [64];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    objset_matcher uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cond_en(cond_en), .cond_val(cond_val),
        .obj_sel(obj_sel), .start(start), .result(result), .done(done)
    );

    function automatic logic [63:0] expect_of(input logic [15:0] en,
                                               input logic [63:0] val,
                                               input logic [63:0] sel);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 64; i++) begin
            logic ok;
            ok = sel[i];
            for (int a = 0; a < 16; a++) begin
                if (en[a] && (((model[i] >> (4*a)) & 64'hF) != ((val >> (4*a)) & 64'hF)))
                    ok = 1'b0;
            end
            r[i] = ok;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_word(input int addr, input logic [63:0] data);
        wr_en = 1; wr_addr = addr[5:0]; wr_data = data;
        @(negedge clk);
        wr_en = 0;
        model[addr] = data;
    endtask

    // Drive at a negedge; sample one full cycle later
    task automatic query(input string req, input logic [15:0] en,
                         input logic [63:0] val, input logic [63:0] sel);
        logic [63:0] exp;
        cond_en = en; cond_val = val; obj_sel = sel; start = 1;
        exp = expect_of(en, val, sel);
        @(negedge clk);
        start = 0;
        chk({req, " done"}, {63'b0, done}, 64'd1);
        chk(req, result, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        logic [63:0] held;
        for (int i = 0; i < 64; i++) model[i] = '0;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 result reset", result, 64'd0);
        chk("R1 done reset", {63'b0, done}, 64'd0);
        rst_n = 1;
        @(negedge clk);
        query("R1 zero table", 16'hFFFF, 64'd0, {64{1'b1}});

        // R2 load table; attribute 15 left zero as unused padding
        for (int i = 0; i < 64; i++) begin
            logic [63:0] w;
            w = '0;
            for (int a = 0; a < 15; a++)
                w[4*a +: 4] = 4'((i >> (a % 4)) + a);
            write_word(i, w);
        end
        query("R2 word readback obj 37", 16'hFFFF, model[37], {64{1'b1}});

        // R3 / R4 empty condition set
        query("R3 empty cond", 16'h0, 64'h0123_4567_89AB_CDEF, 64'hF0F0_1234_8000_0001);
        query("R4 nothing selected", 16'h0, 64'd0, 64'd0);

        // R5 / R8 single attribute sweep, disabled fields filled with garbage
        for (int a = 0; a < 16; a++) begin
            for (int v = 0; v < 16; v++) begin
                logic [63:0] val;
                logic [63:0] sel;
                val = {64{1'b1}} ^ (64'(v ^ a) << 8);
                val[4*a +: 4] = 4'(v);
                sel = (v[0]) ? {64{1'b1}} : ({32{2'b01}} << (a % 2)) | 64'hFFFF;
                query("R5 R8 single attr", 16'(1) << a, val, sel);
            end
        end

        // R5 multi-condition, value built from a target object
        lfsr = 32'hACE1_0F35;
        for (int k = 0; k < 48; k++) begin
            logic [15:0] en;
            logic [63:0] val;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            en  = lfsr[15:0] & lfsr[31:16];
            val = model[k % 64];
            if (k % 5 == 0) val[4*(k % 16) +: 4] = ~val[4*(k % 16) +: 4];
            query("R5 multi cond", en, val, {lfsr, ~lfsr});
        end

        // R4 masked object that would otherwise match
        query("R4 masked match", 16'hFFFF, model[9], ~(64'd1 << 9));

        // R2 write coinciding with start is not seen by that query
        cond_en = 16'h0001; cond_val = 64'hE; obj_sel = {64{1'b1}};
        held = expect_of(16'h0001, 64'hE, {64{1'b1}});
        wr_en = 1; wr_addr = 6'd5; wr_data = 64'hE; start = 1;
        @(negedge clk);
        wr_en = 0; start = 0;
        model[5] = 64'hE;
        chk("R2 same-cycle write hidden", result, held);
        query("R2 write visible after", 16'h0001, 64'hE, {64{1'b1}});

        // R6 done is a single pulse; R7 result held while inputs move
        held = result;
        cond_en = 16'h0; obj_sel = 64'h5; cond_val = 64'h3;
        write_word(6, 64'hFFFF);
        chk("R6 done drops", {63'b0, done}, 64'd0);
        @(negedge clk);
        obj_sel = '0;
        @(negedge clk);
        chk("R7 result held", result, held);
        chk("R7 done low", {63'b0, done}, 64'd0);

        // R6 back-to-back starts
        query("R6 back to back a", 16'h0, 64'd0, 64'h1);
        query("R6 back to back b", 16'h0, 64'd0, 64'h2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule